// File: doc/BRIEF.md
# Adapter Interrupt and Control Register Block

This block holds the host-visible control plane of a network adapter: a strap-driven identity word whose write triggers a soft reset, a sticky interrupt status vector with its own enable mask and write-one-to-clear acknowledge, a master control word, and a pair of saturating discard counters that clear when read. Hardware engines elsewhere on the chip report events as single-cycle pulses. The block folds them into status bits and drives one registered interrupt line toward the host.

Software accesses the block through a simple word-addressed port. `bus_addr` carries the word index, which is the byte offset divided by four. Reads are combinational in the cycle where `bus_sel` is high and `bus_wr` is low. A write takes effect at the clock edge that ends the access cycle. Read side effects, such as clearing the counters, also take effect at that edge.

Top module: `adp_ctl_regs`

## Requirements
- R1: After reset, the following all read as zero: status (word 2), enable (word 3), master control (word 4) and statistics (word 5). `irq_o`, `adp_rst_o` and every `ctl_*` output are low.
- R2: Reading word 0 returns the straps in these fields: `strap_ver` in bits 31:28, `strap_mb` in bits 10:8, `strap_flags` in bits 7:5 and `strap_db` in bits 4:0. All other bits are zero.
- R3: An event pulse sets its status bit, which then stays set. The status bits are mapped as follows:
  - bit 0: statistics overflow
  - bits 8:1: `ev_core[7:0]` (PHY, service list, TX DMA done, RX DMA done, DMA error, bus error, ident mismatch, DMA overflow)
  - bits 16:9: `ev_tx_chan[7:0]`, with channel N at bit N+9
- R4: Writing word 1 clears every status bit whose write-data bit is 1 and leaves the other bits alone. If an event for a bit arrives in the same cycle as its acknowledge, the bit stays set. Word 1 reads as zero.
- R5: `irq_o` is high one clock after any bit is set in both status and enable (word 3, bits 16:0). It is low one clock after no such bit remains.
- R6: In master control, a write sets each of bits 4:0 whose data bit is 1 and leaves it unchanged where the data bit is 0. These bits drive `ctl_dma_en` (bit 4), `ctl_tx_en` (bit 3), `ctl_rx_en` (bit 2), `ctl_wait_1ms` (bit 1) and `ctl_wait_500us` (bit 0). Bits 8:6 (`ctl_irq_lvl`) and bit 5 (`ctl_tx_lock`) take the written value directly.
- R7: Each cycle with `ev_drop_mode` high adds one to the count in bits 31:16 of word 5. Each cycle with `ev_drop_ovf` high adds one to the count in bits 15:0.
- R8: Reading word 5 returns the current counts and clears both counters at that edge. If an increment arrives in the same cycle as the read, that counter holds 1 after the edge.
- R9: Each counter saturates at its all-ones value. The increment that brings either counter to its maximum sets status bit 0.
- R10: A write to word 0 clears status, enable, master control and both counters at that edge. It also raises `adp_rst_o` for exactly the following cycle. The value read from word 0 does not change.
- R11: Writes to word 2 have no effect. Reads of unmapped words 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| strap_ver | input | 4 | Version strap |
| strap_mb | input | 3 | Main board identity strap |
| strap_flags | input | 3 | Board option flags |
| strap_db | input | 5 | Daughter board identity strap |
| ev_tx_chan | input | NUM_TX (8) | Per-channel transmit event pulses |
| ev_core | input | 8 | Engine, PHY and bus event pulses (status bits 8:1) |
| ev_drop_mode | input | 1 | A cell was dropped because of its circuit's mode |
| ev_drop_ovf | input | 1 | A cell was dropped because of buffer overflow |
| irq_o | output | 1 | Registered interrupt request |
| adp_rst_o | output | 1 | One-cycle adapter soft-reset pulse |
| ctl_dma_en | output | 1 | DMA enable |
| ctl_tx_en | output | 1 | Transmit enable |
| ctl_rx_en | output | 1 | Receive enable |
| ctl_wait_1ms | output | 1 | Long wait request |
| ctl_wait_500us | output | 1 | Short wait request |
| ctl_tx_lock | output | 1 | Lock on transmit overflow |
| ctl_irq_lvl | output | 3 | Interrupt priority level |

## Verification
The bench builds the block with CNT_W = 6 and keeps the other parameters at their defaults. With CNT_W = 6, a counter saturates after 63 increments instead of 65535. This lets a short directed run cover the saturation hold and the overflow status bit that the increment reaching the maximum raises. NUM_TX = 8 and ADDR_W = 3 keep the full 17-bit status layout and give two unmapped words to probe.

// File: rtl/adp_ctl_pkg.sv
package adp_ctl_pkg;

  localparam int unsigned N_CORE_EV = 8;

  // word indices of the register file
  localparam int unsigned W_IDENT = 0;
  localparam int unsigned W_ACK   = 1;
  localparam int unsigned W_STAT  = 2;
  localparam int unsigned W_ENA   = 3;
  localparam int unsigned W_MCTL  = 4;
  localparam int unsigned W_DROP  = 5;

  typedef struct packed {
    logic [2:0] lvl;
    logic       lock;
    logic [4:0] en;   // dma, tx, rx, wait_1ms, wait_500us
  } mctl_t;

  localparam int unsigned MCTL_W = $bits(mctl_t);

endpackage

// File: rtl/adp_rst_sync.sv
module adp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adp_drop_ctr.sv
module adp_drop_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             rd_clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_max_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CPRE = CMAX - 1'b1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] base;
  logic             cnt_en;

  always_comb begin
    base  = rd_clr_i ? '0 : cnt_q;
    cnt_d = base;
    if (inc_i && (base != CMAX)) cnt_d = base + 1'b1;
    if (clr_i) cnt_d = '0;
  end

  assign cnt_en    = clr_i | rd_clr_i | inc_i;
  assign hit_max_o = !clr_i && inc_i && (base == CPRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R9: a saturated counter stays at its maximum until it is cleared
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CMAX && !$past(rd_clr_i) && !$past(clr_i)) |-> cnt_q == CMAX);

  // R7: without a clear the count never decreases
  assert_no_decrease_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_clr_i) && !$past(clr_i)) |-> cnt_q >= $past(cnt_q));

  // R8: after a read-clear the count is at most one
  assert_rdclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr_i) |-> cnt_q <= CNT_W'(1));

endmodule

// File: rtl/adp_irq_unit.sv
module adp_irq_unit #(
  parameter int unsigned VEC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [VEC_W-1:0] ev_i,
  input  logic             ack_we_i,
  input  logic [VEC_W-1:0] ack_i,
  input  logic             ena_we_i,
  input  logic [VEC_W-1:0] ena_i,
  output logic [VEC_W-1:0] stat_o,
  output logic [VEC_W-1:0] ena_o,
  output logic             irq_o
);

  logic [VEC_W-1:0] stat_q, stat_d;
  logic [VEC_W-1:0] ena_q, ena_d;
  logic [VEC_W-1:0] ack_mask;
  logic             irq_q, irq_d;
  logic             stat_en, ena_en;

  assign ack_mask = ack_we_i ? ack_i : '0;

  always_comb begin
    stat_d = (stat_q & ~ack_mask) | ev_i;
    if (clr_i) stat_d = '0;
    ena_d = ena_i;
    if (clr_i) ena_d = '0;
    irq_d = clr_i ? 1'b0 : |(stat_q & ena_q);
  end

  assign stat_en = clr_i | ack_we_i | (|ev_i);
  assign ena_en  = clr_i | ena_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (ena_en) ena_q <= ena_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign stat_o = stat_q;
  assign ena_o  = ena_q;
  assign irq_o  = irq_q;

  // R3: bits that were set and not acknowledged stay set
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> ((stat_q & $past(stat_q) & ~$past(ack_mask)) ==
                       ($past(stat_q) & ~$past(ack_mask))));

  // R4: an event wins over an acknowledge in the same cycle
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> ((stat_q & $past(ev_i)) == $past(ev_i)));

  // R5: the interrupt line never rises while nothing was pending
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(stat_q) != '0);

endmodule

// File: rtl/adp_mctl_unit.sv
module adp_mctl_unit
  import adp_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [MCTL_W-1:0] wdata_i,
  output mctl_t             ctl_o
);

  mctl_t ctl_q, ctl_d, wr_v;
  logic  ctl_en;

  assign wr_v = mctl_t'(wdata_i);

  always_comb begin
    ctl_d      = ctl_q;
    ctl_d.lvl  = wr_v.lvl;
    ctl_d.lock = wr_v.lock;
    ctl_d.en   = ctl_q.en | wr_v.en;
    if (clr_i) ctl_d = '0;
  end

  assign ctl_en = clr_i | we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  // R6: the enable bits only fall on a soft reset
  assert_en_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) |-> ((ctl_q.en & $past(ctl_q.en)) == $past(ctl_q.en)));

  // R6: the level field follows the last write
  assert_lvl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we_i) && !$past(clr_i)) |-> ctl_q.lvl == $past(wdata_i[8:6]));

endmodule

// File: rtl/adp_ctl_regs.sv
module adp_ctl_regs
  import adp_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned NUM_TX = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [3:0]        strap_ver,
  input  logic [2:0]        strap_mb,
  input  logic [2:0]        strap_flags,
  input  logic [4:0]        strap_db,
  input  logic [NUM_TX-1:0] ev_tx_chan,
  input  logic [7:0]        ev_core,
  input  logic              ev_drop_mode,
  input  logic              ev_drop_ovf,
  output logic              irq_o,
  output logic              adp_rst_o,
  output logic              ctl_dma_en,
  output logic              ctl_tx_en,
  output logic              ctl_rx_en,
  output logic              ctl_wait_1ms,
  output logic              ctl_wait_500us,
  output logic              ctl_tx_lock,
  output logic [2:0]        ctl_irq_lvl
);

  localparam int unsigned VEC_W  = 1 + N_CORE_EV + NUM_TX;
  localparam int unsigned N_DROP = 2;

  logic              rst_s_n;
  logic              wr_hit, rd_hit;
  logic              id_wr, ack_wr, ena_wr, mctl_wr, drop_rd;
  logic [VEC_W-1:0]  ev_vec, stat_v, ena_v;
  logic [N_DROP-1:0] drop_inc, drop_hit;
  logic [CNT_W-1:0]  drop_cnt [N_DROP];
  logic              adp_rst_q;
  mctl_t             ctl_v;

  adp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // access decode
  assign wr_hit  = bus_sel &  bus_wr;
  assign rd_hit  = bus_sel & ~bus_wr;
  assign id_wr   = wr_hit && (bus_addr == ADDR_W'(W_IDENT));
  assign ack_wr  = wr_hit && (bus_addr == ADDR_W'(W_ACK));
  assign ena_wr  = wr_hit && (bus_addr == ADDR_W'(W_ENA));
  assign mctl_wr = wr_hit && (bus_addr == ADDR_W'(W_MCTL));
  assign drop_rd = rd_hit && (bus_addr == ADDR_W'(W_DROP));

  // discard counters: index 0 counts mode drops, index 1 overflow drops
  assign drop_inc = {ev_drop_ovf, ev_drop_mode};

  for (genvar g = 0; g < N_DROP; g++) begin : g_drop
    adp_drop_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .clr_i     (id_wr),
      .rd_clr_i  (drop_rd),
      .inc_i     (drop_inc[g]),
      .cnt_o     (drop_cnt[g]),
      .hit_max_o (drop_hit[g])
    );
  end

  assign ev_vec = {ev_tx_chan, ev_core, |drop_hit};

  adp_irq_unit #(.VEC_W(VEC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .clr_i    (id_wr),
    .ev_i     (ev_vec),
    .ack_we_i (ack_wr),
    .ack_i    (bus_wdata[VEC_W-1:0]),
    .ena_we_i (ena_wr),
    .ena_i    (bus_wdata[VEC_W-1:0]),
    .stat_o   (stat_v),
    .ena_o    (ena_v),
    .irq_o    (irq_o)
  );

  adp_mctl_unit u_mctl (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr_i   (id_wr),
    .we_i    (mctl_wr),
    .wdata_i (bus_wdata[MCTL_W-1:0]),
    .ctl_o   (ctl_v)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) adp_rst_q <= 1'b0;
    else          adp_rst_q <= id_wr;
  end

  assign adp_rst_o = adp_rst_q;

  // read-back
  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (bus_addr == ADDR_W'(W_IDENT))
        bus_rdata = {strap_ver, 17'b0, strap_mb, strap_flags, strap_db};
      else if (bus_addr == ADDR_W'(W_STAT))
        bus_rdata = 32'(stat_v);
      else if (bus_addr == ADDR_W'(W_ENA))
        bus_rdata = 32'(ena_v);
      else if (bus_addr == ADDR_W'(W_MCTL))
        bus_rdata = 32'(ctl_v);
      else if (bus_addr == ADDR_W'(W_DROP))
        bus_rdata = {16'(drop_cnt[0]), 16'(drop_cnt[1])};
    end
  end

  assign ctl_dma_en     = ctl_v.en[4];
  assign ctl_tx_en      = ctl_v.en[3];
  assign ctl_rx_en      = ctl_v.en[2];
  assign ctl_wait_1ms   = ctl_v.en[1];
  assign ctl_wait_500us = ctl_v.en[0];
  assign ctl_tx_lock    = ctl_v.lock;
  assign ctl_irq_lvl    = ctl_v.lvl;

  // R10: the reset pulse is seen with status, enable and control cleared
  assert_softrst_clear_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    adp_rst_o |-> (stat_v == '0 && ena_v == '0 && ctl_v == '0));

  // R10: the reset pulse only follows a write to the identity word
  assert_softrst_cause_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    adp_rst_o |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(W_IDENT)));

  // R1: the interrupt line is low while the enable mask is empty
  assert_irq_masked_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($past(ena_v) == '0) |-> !irq_o);

endmodule

// File: tb/test_adp_ctl_regs.sv
`timescale 1ns/1ps
module test_adp_ctl_regs;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_TX = 8;
  localparam int unsigned CNT_W  = 6;
  localparam logic [31:0] CMAX   = 32'((1 << CNT_W) - 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic [3:0]        strap_ver = 4'hA;
  logic [2:0]        strap_mb = 3'd5;
  logic [2:0]        strap_flags = 3'b101;
  logic [4:0]        strap_db = 5'd19;
  logic [NUM_TX-1:0] ev_tx_chan = '0;
  logic [7:0]        ev_core = '0;
  logic              ev_drop_mode = 1'b0, ev_drop_ovf = 1'b0;
  logic              irq_o, adp_rst_o;
  logic              ctl_dma_en, ctl_tx_en, ctl_rx_en, ctl_wait_1ms, ctl_wait_500us, ctl_tx_lock;
  logic [2:0]        ctl_irq_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adp_ctl_regs #(.ADDR_W(ADDR_W), .NUM_TX(NUM_TX), .CNT_W(CNT_W)) i_adp_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strap_ver(strap_ver), .strap_mb(strap_mb),
    .strap_flags(strap_flags), .strap_db(strap_db), .ev_tx_chan(ev_tx_chan), .ev_core(ev_core),
    .ev_drop_mode(ev_drop_mode), .ev_drop_ovf(ev_drop_ovf), .irq_o(irq_o), .adp_rst_o(adp_rst_o),
    .ctl_dma_en(ctl_dma_en), .ctl_tx_en(ctl_tx_en), .ctl_rx_en(ctl_rx_en),
    .ctl_wait_1ms(ctl_wait_1ms), .ctl_wait_500us(ctl_wait_500us), .ctl_tx_lock(ctl_tx_lock),
    .ctl_irq_lvl(ctl_irq_lvl)
  );

  // table entry: {write, word, data, expected read data, requirement number}
  typedef struct packed {
    logic        wr;
    logic [2:0]  word;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int N_VEC = 14;
  localparam vec_t VECS [N_VEC] = '{
    '{1'b0, 3'd0, 32'h0, 32'hA000_05B3, 4'd2},   // R2 identity word
    '{1'b1, 3'd4, 32'h155, 32'h0, 4'd6},
    '{1'b0, 3'd4, 32'h0, 32'h155, 4'd6},         // R6 fields written
    '{1'b1, 3'd4, 32'h0, 32'h0, 4'd6},
    '{1'b0, 3'd4, 32'h0, 32'h015, 4'd6},         // R6 zero leaves enables
    '{1'b1, 3'd4, 32'h0EA, 32'h0, 4'd6},
    '{1'b0, 3'd4, 32'h0, 32'h0FF, 4'd6},         // R6 enables accumulate
    '{1'b1, 3'd3, 32'h0001_FFFF, 32'h0, 4'd5},
    '{1'b0, 3'd3, 32'h0, 32'h0001_FFFF, 4'd5},   // R5 enable mask
    '{1'b1, 3'd3, 32'hFFFF_0003, 32'h0, 4'd5},
    '{1'b0, 3'd3, 32'h0, 32'h0001_0003, 4'd5},   // R5 enable width
    '{1'b1, 3'd2, 32'h0001_FFFF, 32'h0, 4'd11},
    '{1'b0, 3'd2, 32'h0, 32'h0, 4'd11},          // R11 status write ignored
    '{1'b0, 3'd6, 32'h0, 32'h0, 4'd11}           // R11 unmapped word
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = w;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic pulse_core(input logic [7:0] c, input logic [NUM_TX-1:0] t);
    @(negedge clk);
    ev_core = c; ev_tx_chan = t;
    @(negedge clk);
    ev_core = '0; ev_tx_chan = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd2, d); check("R1 status", d, 0);
    rd(3'd3, d); check("R1 enable", d, 0);
    rd(3'd4, d); check("R1 control", d, 0);
    rd(3'd5, d); check("R1 stats", d, 0);
    check("R1 irq/rst/ctl", {irq_o, adp_rst_o, ctl_dma_en, ctl_tx_en, ctl_rx_en,
          ctl_wait_1ms, ctl_wait_500us, ctl_tx_lock, ctl_irq_lvl}, 0);

    // register table
    for (int i = 0; i < N_VEC; i++) begin
      if (VECS[i].wr) wr(VECS[i].word, VECS[i].data);
      else begin
        rd(VECS[i].word, d);
        check($sformatf("table[%0d] R%0d", i, VECS[i].req), d, VECS[i].exp);
      end
    end
    check("R6 ctl ports", {ctl_dma_en, ctl_tx_en, ctl_rx_en, ctl_wait_1ms,
          ctl_wait_500us, ctl_tx_lock, ctl_irq_lvl}, 32'b111111011);
    rd(3'd1, d); check("R4 ack reads zero", d, 0);
    rd(3'd7, d); check("R11 word 7", d, 0);

    // R3 event mapping: tx channel 3 -> bit 12, core bit 5 -> bit 6
    pulse_core(8'h20, 8'h08);
    rd(3'd2, d); check("R3 status map", d, 32'h0000_1040);
    check("R5 masked irq low", {31'b0, irq_o}, 0);

    // R4 ack bit 12 and bit 6 while event on bit 6 arrives
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd1; bus_wdata = 32'h1040; ev_core = 8'h20;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; ev_core = 0;
    rd(3'd2, d); check("R4 event beats ack", d, 32'h0000_0040);

    // R5 enable bit 6: irq one cycle after the enable lands
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd3; bus_wdata = 32'h40;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R5 irq not yet", {31'b0, irq_o}, 0);
    @(negedge clk);
    check("R5 irq high", {31'b0, irq_o}, 1);
    wr(3'd1, 32'h40);
    check("R5 irq still high", {31'b0, irq_o}, 1);
    @(negedge clk);
    check("R5 irq falls", {31'b0, irq_o}, 0);

    // R7 counting
    @(negedge clk); ev_drop_mode = 1; ev_drop_ovf = 1;
    repeat (3) @(negedge clk);
    ev_drop_mode = 0;
    repeat (2) @(negedge clk);
    ev_drop_ovf = 0;
    rd(3'd5, d); check("R7 counts", d, 32'h0003_0005);
    rd(3'd5, d); check("R8 cleared on read", d, 0);

    // R8 increment in the read cycle
    @(negedge clk); ev_drop_ovf = 1;
    repeat (2) @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'd5;
    #1 d = bus_rdata;
    check("R8 read value", d, 32'h0000_0002);
    @(negedge clk);
    bus_sel = 0; ev_drop_ovf = 0;
    rd(3'd5, d); check("R8 increment kept", d, 32'h0000_0001);

    // R9 saturation and overflow status
    rd(3'd2, d); check("R9 no overflow yet", d, 0);
    @(negedge clk); ev_drop_mode = 1;
    repeat (70) @(negedge clk);
    ev_drop_mode = 0;
    rd(3'd5, d); check("R9 saturated", d, CMAX << 16);
    rd(3'd2, d); check("R9 overflow status", d, 32'h1);

    // R10 soft reset via identity word
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h1FF);
    @(negedge clk); ev_drop_ovf = 1;
    @(negedge clk); ev_drop_ovf = 0;
    check("R10 irq before", {31'b0, irq_o}, 1);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'd0; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R10 pulse high", {31'b0, adp_rst_o}, 1);
    @(negedge clk);
    check("R10 pulse one cycle", {31'b0, adp_rst_o}, 0);
    check("R10 ctl cleared", {irq_o, ctl_dma_en, ctl_tx_en, ctl_rx_en, ctl_wait_1ms,
          ctl_wait_500us, ctl_tx_lock, ctl_irq_lvl}, 0);
    rd(3'd2, d); check("R10 status", d, 0);
    rd(3'd3, d); check("R10 enable", d, 0);
    rd(3'd5, d); check("R10 stats", d, 0);
    rd(3'd0, d); check("R10 id kept", d, 32'hA000_05B3);

    // R2 with different straps
    strap_ver = 4'h3; strap_mb = 3'd2; strap_flags = 3'b010; strap_db = 5'd1;
    rd(3'd0, d); check("R2 straps", d, 32'h3000_0241);

    finish_run();
  end

endmodule